// File: doc/BRIEF.md
# Serial Transmitter with Holding-Register Status

This block is the transmit half of an asynchronous serial port. Software writes a byte into a one-entry holding register. The block moves that byte into a shift register and sends it on a single output line as a framed character. All timing comes from an enable that pulses once per sixteenth of a bit, so every bit lasts sixteen of those pulses. The frame is set by static inputs: the number of data bits (5 to 8), an optional even or odd parity bit, and one or two stop bits.

Three status outputs go back to the host. The first says the holding register can accept a byte. The second is the "transmitter empty" status bit, and a mode input chooses its meaning. In standard mode it is true only when both the holding register and the shift register are empty. In legacy mode it reflects only the shift register. The third output is an interrupt condition. It is raised in the middle of the first stop bit when no further byte is waiting, and any write to the holding register clears it.

When a byte is written to an idle transmitter, one bit time of idle line comes before its start bit. When a byte is already waiting as a frame ends, it is loaded in the same tick and its start bit follows with no gap.

Top module: `uart_tx_status`

## Requirements
- R1: After reset, `txd` is 1, `thr_empty` is 1, `b6_empty` is 1 and `thr_irq` is 0.
- R2: A `thr_wr` pulse makes `thr_empty` read 0 in the next clock cycle. In standard mode it also makes `b6_empty` read 0 in that cycle.
- R3: With the line idle, the held byte enters the shift register on the first `tick16` after the write, and `thr_empty` returns to 1 at that tick. `txd` stays 1 for 16 more ticks, and the start bit begins on the 16th tick after the transfer.
- R4: A frame is a 0 start bit followed by the data bits, least significant bit first. The count is set by `word_len`: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8. Data bits above that count are not sent. Every bit lasts 16 ticks, and the idle line is 1.
- R5: With `par_en` set, one parity bit follows the data. Its value is the XOR of the sent data bits when `par_odd` is 0, and the inverse of that XOR when `par_odd` is 1.
- R6: A frame ends with one stop bit at 1, or two when `stop2` is 1.
- R7: If a byte is held when the last stop bit ends, it is loaded on that same tick. Its start bit begins at once, and `thr_empty` becomes 1 at that tick.
- R8: A write that lands on the same edge as a transfer out of the holding register keeps the new byte. `thr_empty` stays 0, and that byte is sent as the next frame.
- R9: In standard mode (`legacy_b6`=0), `b6_empty` becomes 1 two ticks after the last stop bit ends, and only if the holding register is empty. It is 0 while the line is still settling.
- R10: In legacy mode (`legacy_b6`=1), `b6_empty` is 1 whenever the shift register is empty. This covers the cycles between a write and its transfer, and starts from the tick the last stop bit ends. It is 0 while a byte is loaded, including the idle lead-in before the start bit.
- R11: `thr_irq` is set on the 8th tick of the first stop bit if the holding register is empty at that point. It stays set until a write, and a write clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sixteen-times-bit-rate enable |
| thr_wr | input | 1 | Write strobe for the holding register |
| thr_data | input | 8 | Byte to write |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop2 | input | 1 | 1 selects two stop bits |
| legacy_b6 | input | 1 | 1 selects shift-register-only empty status |
| txd | output | 1 | Serial line, idle high |
| thr_empty | output | 1 | Holding register can accept a byte |
| b6_empty | output | 1 | Transmitter-empty status bit, mode dependent |
| thr_irq | output | 1 | Holding-register-empty interrupt condition |

## Verification
Two events can fall on the same clock edge: a host write into the holding register, and the move of the held byte into the shift register when a frame ends. The bench provokes this by queueing a byte behind a running frame. It then writes a third byte on exactly the edge where the last stop bit completes, so the write lands as the queued byte leaves the holding register. The result is judged at the ports. `thr_empty` must stay 0, the queued byte must start without a gap, the third byte must follow it bit for bit, and the interrupt must stay low until the third frame's stop bit.

// File: rtl/uart_tx_status.sv
module uart_tx_status #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       thr_wr,
  input  logic [7:0] thr_data,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       stop2,
  input  logic       legacy_b6,
  output logic       txd,
  output logic       thr_empty,
  output logic       b6_empty,
  output logic       thr_irq
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_START, S_DATA, S_PAR, S_STOP, S_DRAIN
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    hold, sh;
  logic          hold_full, par;

  wire       bit_end   = tick16 && cnt == LAST;
  wire       shf_free  = st == S_IDLE || st == S_DRAIN;
  wire [2:0] last_idx  = {1'b1, word_len};
  wire       stop_done = bit_end && st == S_STOP && (idx[0] || !stop2);
  wire       xfer      = hold_full && ((tick16 && shf_free) || stop_done);

  assign txd       = st == S_START ? 1'b0 :
                     st == S_DATA  ? sh[0] :
                     st == S_PAR   ? par : 1'b1;
  assign thr_empty = !hold_full;
  assign b6_empty  = legacy_b6 ? shf_free : (st == S_IDLE && !hold_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      idx       <= '0;
      hold      <= '0;
      sh        <= '0;
      hold_full <= 1'b0;
      par       <= 1'b0;
      thr_irq   <= 1'b0;
    end else begin
      if (thr_wr) hold <= thr_data;
      hold_full <= thr_wr || (hold_full && !xfer);

      if (thr_wr)
        thr_irq <= 1'b0;
      else if (tick16 && st == S_STOP && idx == 3'd0 && cnt == MID && !hold_full)
        thr_irq <= 1'b1;

      if (xfer) sh <= hold;

      if (tick16) begin
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        case (st)
          S_IDLE: begin
            cnt <= '0;
            if (hold_full) st <= S_LEAD;
          end
          S_DRAIN: begin
            if (hold_full) begin
              st  <= S_LEAD;
              cnt <= '0;
            end else if (cnt == ONE) begin
              st  <= S_IDLE;
              cnt <= '0;
            end
          end
          S_LEAD:
            if (cnt == LAST) st <= S_START;
          S_START:
            if (cnt == LAST) begin
              st  <= S_DATA;
              idx <= '0;
              par <= par_odd;
            end
          S_DATA:
            if (cnt == LAST) begin
              par <= par ^ sh[0];
              sh  <= sh >> 1;
              if (idx == last_idx) begin
                st  <= par_en ? S_PAR : S_STOP;
                idx <= '0;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          S_PAR:
            if (cnt == LAST) begin
              st  <= S_STOP;
              idx <= '0;
            end
          S_STOP:
            if (cnt == LAST) begin
              if (stop2 && idx == 3'd0) idx <= 3'd1;
              else if (hold_full)       st  <= S_START;
              else                      st  <= S_DRAIN;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_status_chk.sv
module uart_tx_status_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic thr_wr,
  input logic legacy_b6,
  input logic txd,
  input logic thr_empty,
  input logic b6_empty,
  input logic thr_irq
);
  p_wr_clears_thre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thr_empty);

  p_wr_clears_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thr_irq);

  p_std_b6_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy_b6 && b6_empty) |-> (thr_empty && txd));

  p_txd_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> $stable(txd));

  p_thre_sets_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thr_empty) |-> $past(tick16));
endmodule

bind uart_tx_status uart_tx_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .thr_wr(thr_wr),
  .legacy_b6(legacy_b6), .txd(txd), .thr_empty(thr_empty),
  .b6_empty(b6_empty), .thr_irq(thr_irq)
);

// File: tb/tb_uart_tx_status.sv
module tb_uart_tx_status;
  localparam int CLK_P = 10;
  localparam int TDIV  = 3;
  localparam int BT    = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       thr_wr = 1'b0;
  logic [7:0] thr_data = '0;
  logic [1:0] word_len = '0;
  logic       par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, legacy_b6 = 1'b0;
  logic       tick16, txd, thr_empty, b6_empty, thr_irq;

  int cyc = 0, tcnt = 0, n_tests = 0, n_fail = 0;

  always #(CLK_P / 2) clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;
  assign tick16 = rst_n && (cyc % TDIV == TDIV - 1);
  always_ff @(posedge clk) if (tick16) tcnt <= tcnt + 1;

  uart_tx_status dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .thr_wr(thr_wr),
    .thr_data(thr_data), .word_len(word_len), .par_en(par_en),
    .par_odd(par_odd), .stop2(stop2), .legacy_b6(legacy_b6),
    .txd(txd), .thr_empty(thr_empty), .b6_empty(b6_empty), .thr_irq(thr_irq)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at tick %0d: got %b expected %b", req, what, tcnt, act, exp);
    end
  endtask

  task automatic wait_t(input int t);
    while (tcnt < t) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, output int w);
    @(negedge clk);
    while (tick16) @(negedge clk);
    thr_wr = 1'b1;
    thr_data = d;
    w = tcnt;
    @(negedge clk);
    thr_wr = 1'b0;
  endtask

  task automatic frame(input int s, input logic [7:0] d, input logic irq_exp, output int f);
    logic bits [12];
    int n = 0, nb = 5 + int'(word_len), ns = stop2 ? 2 : 1, e;
    logic [7:0] mask = 8'((1 << nb) - 1);
    bits[n++] = 1'b0;
    for (int i = 0; i < nb; i++) bits[n++] = d[i];
    if (par_en) bits[n++] = (^(d & mask)) ^ par_odd;
    for (int k = 0; k < n; k++) begin
      wait_t(s + BT / 2 + BT * k);
      chk(k == 0 ? "R4" : (par_en && k == n - 1) ? "R5" : "R4", $sformatf("bit %0d", k), txd, bits[k]);
    end
    e = s + BT * n;
    wait_t(e + BT / 2 - 1);
    chk("R11", "irq before mid stop", thr_irq, 1'b0);
    for (int j = 0; j < ns; j++) begin
      wait_t(e + BT / 2 + BT * j);
      chk("R6", $sformatf("stop %0d", j), txd, 1'b1);
      if (j == 0) chk("R11", "irq at mid stop", thr_irq, irq_exp);
    end
    f = e + BT * ns;
  endtask

  task automatic single(input logic [7:0] d);
    int w, f;
    wr(d, w);
    chk("R2", "thre after write", thr_empty, 1'b0);
    chk("R11", "irq cleared by write", thr_irq, 1'b0);
    chk(legacy_b6 ? "R10" : "R2", "b6 after write", b6_empty, legacy_b6);
    wait_t(w + 1);
    chk("R3", "thre at transfer", thr_empty, 1'b1);
    chk(legacy_b6 ? "R10" : "R9", "b6 during lead", b6_empty, 1'b0);
    wait_t(w + BT);
    chk("R3", "line high in lead", txd, 1'b1);
    wait_t(w + BT + 1);
    chk("R3", "start edge", txd, 1'b0);
    frame(w + BT + 1, d, 1'b1, f);
    wait_t(f);
    chk("R4", "idle high", txd, 1'b1);
    chk(legacy_b6 ? "R10" : "R9", "b6 at stop end", b6_empty, legacy_b6);
    wait_t(f + 1);
    chk(legacy_b6 ? "R10" : "R9", "b6 one tick later", b6_empty, legacy_b6);
    wait_t(f + 2);
    chk("R9", "b6 two ticks later", b6_empty, 1'b1);
    chk("R11", "irq held", thr_irq, 1'b1);
  endtask

  task automatic triple(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    int w, w2, f, f2, f3;
    wr(a, w);
    wait_t(w + 2);
    wr(b, w2);
    chk("R7", "thre with byte queued", thr_empty, 1'b0);
    frame(w + BT + 1, a, 1'b0, f);
    while (!(tcnt == f - 1 && tick16)) @(negedge clk);
    thr_wr = 1'b1;
    thr_data = c;
    @(negedge clk);
    thr_wr = 1'b0;
    chk("R8", "thre after collision", thr_empty, 1'b0);
    chk("R7", "no gap start", txd, 1'b0);
    chk(legacy_b6 ? "R10" : "R9", "b6 on reload", b6_empty, 1'b0);
    frame(f, b, 1'b0, f2);
    wait_t(f2);
    chk("R7", "thre at second reload", thr_empty, 1'b1);
    chk("R8", "third start", txd, 1'b0);
    frame(f2, c, 1'b1, f3);
    wait_t(f3 + 2);
    chk("R9", "b6 after run", b6_empty, 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int idx = 0;
    repeat (3) @(negedge clk);
    chk("R1", "txd", txd, 1'b1);
    chk("R1", "thre", thr_empty, 1'b1);
    chk("R1", "b6", b6_empty, 1'b1);
    chk("R1", "irq", thr_irq, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int lg = 0; lg < 2; lg++)
      for (int wl = 0; wl < 4; wl++)
        for (int pm = 0; pm < 3; pm++)
          for (int sb = 0; sb < 2; sb++) begin
            legacy_b6 = lg[0];
            word_len  = wl[1:0];
            par_en    = pm != 0;
            par_odd   = pm == 2;
            stop2     = sb[0];
            single(8'(8'h3C + 37 * idx));
            idx++;
          end
    for (int lg = 0; lg < 2; lg++) begin
      legacy_b6 = lg[0];
      word_len  = 2'd3;
      par_en    = lg[0];
      par_odd   = 1'b1;
      stop2     = !lg[0];
      triple(8'hD2, 8'h4B, 8'h81);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule